// File: doc/BRIEF.md
# Immediate Shift Execute Unit

This block executes the three shift-by-constant operations of a 32-bit integer pipeline. It takes a valid strobe, a 32-bit instruction word and the operand already fetched from the source register. It decides whether the word is one of its shifts, pulls the shift distance out of the instruction itself, and shifts the operand. The shift can go left with zero fill, right with zero fill, or right with the sign bit copied in. Result, destination index and write-enable come out of registers one clock after the strobe.

Words whose major opcode or function field belong to some other operation are left alone. The unit neither writes nor complains, so that a neighbouring unit can take them. Words that do carry the shift opcode and function field, but have a bad pattern in their upper seven bits, raise an illegal flag and never write. Writes to register index 0 are dropped.

Top module: `shimm_exec_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `wen_o`, `illegal_o`, `rd_o` and `res_o` read 0 until the first accepted word takes effect.
- R2: A valid word whose bits [6:0] are not 7'b0010011 gives `wen_o`=0 and `illegal_o`=0 in the following cycle.
- R3: A valid word with bits [6:0]=7'b0010011 and bits [14:12] other than 3'b001 or 3'b101 gives `wen_o`=0 and `illegal_o`=0, whatever its upper bits are.
- R4: Bits [14:12]=3'b001 with bits [31:25]=7'b0000000 shift the operand left and fill the vacated low bits with 0.
- R5: Bits [14:12]=3'b101 with bits [31:25]=7'b0000000 shift the operand right and fill the vacated high bits with 0.
- R6: Bits [14:12]=3'b101 with bits [31:25]=7'b0100000 shift the operand right and fill the vacated high bits with operand bit 31.
- R7: The shift distance is bits [24:20], taken as an unsigned value from 0 to 31. A distance of 0 returns the operand unchanged.
- R8: `rd_o` is bits [11:7] of the last valid word. Word 0x00361693 with operand 1 gives rd 13, result 8 and a write.
- R9: A shift word whose bits [31:25] do not match its allowed pattern (only 7'b0000000 for the left shift; 7'b0000000 or 7'b0100000 for the right shift) gives `illegal_o`=1 and `wen_o`=0. `res_o` is not changed.
- R10: Outputs change one clock after the valid cycle. A cycle with `valid_i` low gives `wen_o`=0 and `illegal_o`=0 in the next cycle.
- R11: A legal shift whose bits [11:7] are 0 gives `wen_o`=0 and `illegal_o`=0.
- R12: `res_o` keeps its value in every cycle that does not follow an accepted legal shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| valid_i | input | 1 | Instruction word and operand are valid this cycle |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | Source operand value |
| res_o | output | XLEN | Registered shift result |
| rd_o | output | 5 | Registered destination index |
| wen_o | output | 1 | Registered write-enable |
| illegal_o | output | 1 | Registered illegal-encoding flag |

## Verification
The case where two functions meet in one cycle is an upper-bit violation together with a zero destination index. Both suppress the write, but only the violation raises the illegal flag, so the bench sends such words and expects the flag high and no write. A second meeting point is a bad upper pattern on a word whose function field is not a shift. There the unclaimed-word rule must win and leave the illegal flag low. Directed words cover these cases, and a random mix of claimed, unclaimed and malformed words follows them. A behavioural model checks every cycle of that mix.

// File: rtl/shimm_pkg.sv
package shimm_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned AMT_W  = 5;
  localparam int unsigned REG_W  = 5;

  localparam logic [6:0] OPC_IMM_ARITH = 7'b0010011;
  localparam logic [2:0] F3_SHL        = 3'b001;
  localparam logic [2:0] F3_SHR        = 3'b101;
  localparam logic [6:0] UP_PLAIN      = 7'b0000000;
  localparam logic [6:0] UP_SIGNED     = 7'b0100000;

  typedef enum logic [1:0] {
    SH_LEFT_ZERO  = 2'd0,
    SH_RIGHT_ZERO = 2'd1,
    SH_RIGHT_SIGN = 2'd2
  } shift_kind_e;

  typedef struct packed {
    logic               claim;
    logic               legal;
    shift_kind_e        kind;
    logic [AMT_W-1:0]   amt;
    logic [REG_W-1:0]   rd;
  } shimm_dec_t;

endpackage

// File: rtl/shimm_decode.sv
module shimm_decode
  import shimm_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output shimm_dec_t        dec_o
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] upper;
  logic       is_shl;
  logic       is_shr;
  logic       upper_ok;

  assign opc   = insn_i[6:0];
  assign f3    = insn_i[14:12];
  assign upper = insn_i[31:25];

  assign is_shl = (opc == OPC_IMM_ARITH) && (f3 == F3_SHL);
  assign is_shr = (opc == OPC_IMM_ARITH) && (f3 == F3_SHR);

  always_comb begin
    upper_ok = 1'b0;
    if (is_shl) begin
      upper_ok = (upper == UP_PLAIN);
    end else if (is_shr) begin
      upper_ok = (upper == UP_PLAIN) || (upper == UP_SIGNED);
    end
  end

  always_comb begin
    dec_o       = '0;
    dec_o.claim = is_shl || is_shr;
    dec_o.legal = upper_ok;
    dec_o.amt   = insn_i[24:20];
    dec_o.rd    = insn_i[11:7];
    if (is_shl) begin
      dec_o.kind = SH_LEFT_ZERO;
    end else if (insn_i[30]) begin
      dec_o.kind = SH_RIGHT_SIGN;
    end else begin
      dec_o.kind = SH_RIGHT_ZERO;
    end
  end

  // R9: a legal decode is always a claimed one
  always_comb begin
    a_r9_legal_implies_claim: assert (!dec_o.legal || dec_o.claim)
      else $error("legal decode outside shift space");
  end

endmodule

// File: rtl/shimm_shifter.sv
module shimm_shifter
  import shimm_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  din_i,
  input  logic [AMT_W-1:0] amt_i,
  input  shift_kind_e      kind_i,
  output logic [XLEN-1:0]  dout_o
);

  localparam int unsigned STAGES = AMT_W;

  logic                         left;
  logic                         fill;
  logic [XLEN-1:0]              din_rev;
  logic [XLEN-1:0]              net_rev;
  logic [STAGES:0][XLEN-1:0]    net;

  assign left = (kind_i == SH_LEFT_ZERO);
  assign fill = (kind_i == SH_RIGHT_SIGN) & din_i[XLEN-1];

  for (genvar b = 0; b < XLEN; b++) begin : g_rev
    assign din_rev[b] = din_i[XLEN-1-b];
    assign net_rev[b] = net[STAGES][XLEN-1-b];
  end

  assign net[0] = left ? din_rev : din_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int unsigned DIST = 2 ** s;
    if (DIST < XLEN) begin : g_shift
      assign net[s+1] = amt_i[s] ? {{DIST{fill}}, net[s][XLEN-1:DIST]} : net[s];
    end else begin : g_flush
      assign net[s+1] = amt_i[s] ? {XLEN{fill}} : net[s];
    end
  end

  assign dout_o = left ? net_rev : net[STAGES];

  // R7: zero distance leaves the operand untouched
  always_comb begin
    if (!$isunknown(amt_i) && !$isunknown(din_i) && amt_i == '0) begin
      a_r7_zero_amount_identity: assert (dout_o == din_i)
        else $error("zero shift altered operand");
    end
  end

endmodule

// File: rtl/shimm_exec_unit.sv
module shimm_exec_unit
  import shimm_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [31:0]      insn_i,
  input  logic [XLEN-1:0]  rs1_val_i,
  output logic [XLEN-1:0]  res_o,
  output logic [4:0]       rd_o,
  output logic             wen_o,
  output logic             illegal_o
);

  shimm_dec_t       dec;
  logic [XLEN-1:0]  shifted;

  logic [XLEN-1:0]  res_q, res_d;
  logic [REG_W-1:0] rd_q, rd_d;
  logic             wen_q, wen_d;
  logic             ill_q, ill_d;
  logic             res_en;
  logic             rd_en;

  shimm_decode u_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  shimm_shifter #(.XLEN(XLEN)) u_shift (
    .din_i  (rs1_val_i),
    .amt_i  (dec.amt),
    .kind_i (dec.kind),
    .dout_o (shifted)
  );

  // clock enables
  assign res_en = valid_i & dec.claim & dec.legal;
  assign rd_en  = valid_i;

  // next state
  always_comb begin
    res_d = shifted;
    rd_d  = dec.rd;
    wen_d = 1'b0;
    ill_d = 1'b0;
    if (valid_i && dec.claim) begin
      if (dec.legal) begin
        wen_d = (dec.rd != '0);
      end else begin
        ill_d = 1'b1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      rd_q  <= '0;
      wen_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      wen_q <= wen_d;
      ill_q <= ill_d;
      if (res_en) res_q <= res_d;
      if (rd_en)  rd_q  <= rd_d;
    end
  end

  assign res_o     = res_q;
  assign rd_o      = rd_q;
  assign wen_o     = wen_q;
  assign illegal_o = ill_q;

  // R9: flag and write never together
  a_r9_illegal_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !wen_o);

  // R11: a write never targets index 0
  a_r11_no_write_rd0: assert property (@(posedge clk) disable iff (!rst_n)
    wen_o |-> (rd_o != '0));

  // R10: an idle cycle yields no write and no flag next cycle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!wen_o && !illegal_o));

  // R12: result holds across idle cycles
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(res_o));

  // R2: foreign opcode is never claimed
  a_r2_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && insn_i[6:0] != 7'b0010011) |=> (!wen_o && !illegal_o));

  // R4: a nonzero left shift clears the lowest result bit
  a_r4_left_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && insn_i[6:0] == 7'b0010011 && insn_i[14:12] == 3'b001 &&
     insn_i[31:25] == 7'b0 && insn_i[24:20] != 5'd0) |=> !res_o[0]);

  // R6: signed right shift keeps the sign bit
  a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && insn_i[6:0] == 7'b0010011 && insn_i[14:12] == 3'b101 &&
     insn_i[31:25] == 7'b0100000 && rs1_val_i[XLEN-1]) |=> res_o[XLEN-1]);

endmodule

// File: tb/shimm_exec_unit_test.sv
module shimm_exec_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [31:0] insn_i;
  logic [31:0] rs1_val_i;
  logic [31:0] res_o;
  logic [4:0]  rd_o;
  logic        wen_o;
  logic        illegal_o;

  int errors = 0;
  int checks = 0;

  // reference state
  logic [31:0] m_res;
  logic [4:0]  m_rd;
  logic        m_wen;
  logic        m_ill;
  string       cur_tag;

  always #5 clk = ~clk;

  shimm_exec_unit #(.XLEN(32)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .insn_i    (insn_i),
    .rs1_val_i (rs1_val_i),
    .res_o     (res_o),
    .rd_o      (rd_o),
    .wen_o     (wen_o),
    .illegal_o (illegal_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [6:0] up, input logic [4:0] sh,
                                      input logic [4:0] rs, input logic [2:0] f3,
                                      input logic [4:0] rd, input logic [6:0] op);
    return {up, sh, rs, f3, rd, op};
  endfunction

  // one cycle: compare outputs, then drive next word and advance the model
  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] a,
                      input string tag);
    @(negedge clk);
    check(cur_tag, "wen", {31'd0, wen_o}, {31'd0, m_wen});
    check(cur_tag, "illegal", {31'd0, illegal_o}, {31'd0, m_ill});
    check(cur_tag, "rd", {27'd0, rd_o}, {27'd0, m_rd});
    check(cur_tag, "res", res_o, m_res);
    valid_i   = v;
    insn_i    = w;
    rs1_val_i = a;
    cur_tag   = tag;
    m_wen = 1'b0;
    m_ill = 1'b0;
    if (v) begin
      m_rd = w[11:7];
      if (w[6:0] == 7'h13 && (w[14:12] == 3'd1 || w[14:12] == 3'd5)) begin
        logic ok;
        int   n;
        n  = int'(w[24:20]);
        ok = (w[14:12] == 3'd1) ? (w[31:25] == 7'h00)
                                : (w[31:25] == 7'h00 || w[31:25] == 7'h20);
        if (ok) begin
          if (w[14:12] == 3'd1)  m_res = a << n;
          else if (w[30])        m_res = 32'($signed(a) >>> n);
          else                   m_res = a >> n;
          m_wen = (w[11:7] != 5'd0);
        end else begin
          m_ill = 1'b1;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    valid_i   = 1'b1;
    insn_i    = 32'h00361693;
    rs1_val_i = 32'hFFFF_FFFF;
    m_res = '0; m_rd = '0; m_wen = 1'b0; m_ill = 1'b0;
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    // R1: values held in reset even with a live word presented
    check("R1", "wen in reset", {31'd0, wen_o}, 32'd0);
    check("R1", "illegal in reset", {31'd0, illegal_o}, 32'd0);
    check("R1", "res in reset", res_o, 32'd0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R8: the reference encoding
    step(1'b1, 32'h00361693, 32'd1, "R8");
    // R4 / R7: full-width left shift
    step(1'b1, enc(7'h00, 5'd31, 5'd1, 3'd1, 5'd2, 7'h13), 32'hFFFF_FFFF, "R4");
    step(1'b1, enc(7'h00, 5'd4, 5'd1, 3'd1, 5'd3, 7'h13), 32'h1234_5678, "R4");
    // R5: zero-fill right
    step(1'b1, enc(7'h00, 5'd31, 5'd1, 3'd5, 5'd4, 7'h13), 32'h8000_0000, "R5");
    step(1'b1, enc(7'h00, 5'd3, 5'd1, 3'd5, 5'd4, 7'h13), 32'hCC00_0000, "R5");
    // R6: sign-fill right, negative and positive operands
    step(1'b1, enc(7'h20, 5'd3, 5'd1, 3'd5, 5'd5, 7'h13), 32'hCC00_0000, "R6");
    step(1'b1, enc(7'h20, 5'd3, 5'd1, 3'd5, 5'd5, 7'h13), 32'h3300_0000, "R6");
    step(1'b1, enc(7'h20, 5'd31, 5'd1, 3'd5, 5'd5, 7'h13), 32'h8000_0001, "R6");
    // R7: zero distance
    step(1'b1, enc(7'h20, 5'd0, 5'd1, 3'd5, 5'd6, 7'h13), 32'hA5A5_0F0F, "R7");
    // R9: bad upper patterns
    step(1'b1, enc(7'h01, 5'd2, 5'd1, 3'd1, 5'd7, 7'h13), 32'h0000_0001, "R9");
    step(1'b1, enc(7'h20, 5'd2, 5'd1, 3'd1, 5'd7, 7'h13), 32'h0000_0001, "R9");
    step(1'b1, enc(7'h21, 5'd2, 5'd1, 3'd5, 5'd7, 7'h13), 32'h0000_0001, "R9");
    // R11: legal with rd 0; then rd 0 plus bad upper bits
    step(1'b1, enc(7'h00, 5'd1, 5'd1, 3'd1, 5'd0, 7'h13), 32'h0000_0003, "R11");
    step(1'b1, enc(7'h40, 5'd1, 5'd1, 3'd5, 5'd0, 7'h13), 32'h0000_0003, "R11");
    // R2: foreign opcode with shift-shaped fields
    step(1'b1, enc(7'h00, 5'd1, 5'd1, 3'd1, 5'd8, 7'h33), 32'h0000_00FF, "R2");
    // R3: other function field, bad upper bits
    step(1'b1, enc(7'h7F, 5'd1, 5'd1, 3'd0, 5'd9, 7'h13), 32'h0000_00FF, "R3");
    step(1'b1, enc(7'h01, 5'd1, 5'd1, 3'd3, 5'd9, 7'h13), 32'h0000_00FF, "R3");
    // R10 / R12: idle cycles with garbage on the inputs
    step(1'b0, enc(7'h00, 5'd1, 5'd1, 3'd1, 5'd10, 7'h13), 32'hDEAD_BEEF, "R10");
    step(1'b0, 32'hFFFF_FFFF, 32'h1, "R12");

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [6:0] up, op;
      logic [2:0] f3;
      int         r;
      r  = int'($urandom_range(0, 9));
      up = (r < 4) ? 7'h00 : (r < 7) ? 7'h20 : 7'($urandom);
      r  = int'($urandom_range(0, 9));
      f3 = (r < 4) ? 3'd1 : (r < 8) ? 3'd5 : 3'($urandom);
      op = ($urandom_range(0, 9) < 8) ? 7'h13 : 7'($urandom);
      step(($urandom_range(0, 4) != 0),
           enc(up, 5'($urandom), 5'($urandom), f3, 5'($urandom), op),
           $urandom, "R10");
    end
    step(1'b0, 32'd0, 32'd0, "R12");
    step(1'b0, 32'd0, 32'd0, "R12");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule